// File: doc/BRIEF.md
# Auto-Selecting Divided Clock Source

This block supplies the working clock for the low-power supply mode of a battery power manager. At start-up it passes an internal RC oscillator to its clock output. A host may also drive an external clock pin. The block divides that clock by a power of two chosen by a 3-bit pin code. When it sees steady activity on the divided external clock, it hands the output over to that clock on its own, and it hands back to the oscillator when the external clock stops.

Activity is counted in the internal clock domain over fixed windows. The handover between the two sources is glitch-free: the clock being left is gated off while it is low, and only then is the new one gated on, also while it is low. The clock output runs only while the mode enable is high, which covers the load-supply mode and the programming mode. In deep sleep the output stays low.

The block carries no data stream, so it has no valid/ready interface. All pins are plain clock, control or status signals.

Top module: `clk_source_select`

## Requirements
- R1: While the external source is active, the output clock period equals the external clock period times 2^(div_code+1). Code 0 divides by 2 and code 7 divides by 256.
- R2: While rst_n is low, clk_out, src_ext and ext_present are all 0. After reset, with no external activity and mode_en high, clk_out follows clk_int (period of one internal cycle), with src_ext=0 and ext_present=0.
- R3: ext_present is set at the end of a WIN_CYC-cycle window in which at least EDGE_MIN rising edges of the divided external clock were seen. It stays 0 before EDGE_MIN such edges have occurred.
- R4: Once ext_present is set and mode_en is high, the output is handed to the divided external clock, and src_ext reads 1.
- R5: After a full window with no divided-clock rising edge, ext_present clears. The external gate closes within one internal cycle after that, and clk_out returns to the internal oscillator.
- R6: While mode_en is low, clk_out stays low and src_ext is 0. This takes effect within a few internal cycles plus one divided-clock period.
- R7: The two source gates are never open at the same time. No clk_out pulse is shorter than the shorter half period of the two sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal RC oscillator clock; the detector runs on it |
| clk_ext | input | 1 | External clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 3 | Divide code: ratio 2^(code+1) |
| mode_en | input | 1 | High in load-supply or programming mode; low in deep sleep |
| clk_out | output | 1 | Selected, gated clock |
| src_ext | output | 1 | 1 while the divided external clock drives clk_out |
| ext_present | output | 1 | Divided external clock judged active |

## Verification
Detection completes within two windows plus two synchronizer cycles (about 35 internal cycles at the defaults). The handover to the external source then takes up to two divided-clock periods more. Loss of the external clock is seen after at most two windows, and the gate closes one cycle later. A change on mode_en acts after two synchronizer stages plus one gate stage. The bench therefore samples status 60 internal cycles after starting or stopping the external clock, and 10 to 30 cycles after a mode change, always 1 ns after a rising edge. It also checks ext_present early, 8 cycles after start, when it must still be 0. Output periods come from timestamps of consecutive clk_out rising edges, taken once the handover has settled.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int CODE_W     = 3;
  localparam int DIV_STAGES = 1 << CODE_W;
  typedef logic [CODE_W-1:0] div_code_t;
endpackage

// File: rtl/clksel_divider.sv
// Ripple-free binary counter on the external clock; bit n has a period of 2^(n+1) input cycles.
module clksel_divider
  import clksel_pkg::*;
(
  input  logic      clk_ext,
  input  logic      rst_n,
  input  div_code_t div_code,
  output logic      clk_div
);
  localparam logic [DIV_STAGES-1:0] ONE = DIV_STAGES'(1);
  logic [DIV_STAGES-1:0] cnt;

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + ONE;
  end

  assign clk_div = cnt[div_code];
endmodule

// File: rtl/clksel_detect.sv
// Counts rising edges of the divided clock per window, in the internal domain.
module clksel_detect #(
  parameter int WIN_CYC     = 16,
  parameter int EDGE_MIN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_int,
  input  logic rst_n,
  input  logic clk_div,
  output logic present
);
  localparam int WIN_W = $clog2(WIN_CYC);
  localparam int EC_W  = $clog2(EDGE_MIN + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
  localparam logic [WIN_W-1:0] WIN_ONE  = WIN_W'(1);
  localparam logic [EC_W-1:0]  EMIN     = EC_W'(EDGE_MIN);
  localparam logic [EC_W-1:0]  EC_ONE   = EC_W'(1);

  logic [SYNC_STAGES:0] smp;
  logic [WIN_W-1:0]     win_cnt;
  logic [EC_W-1:0]      ecnt, tot;
  logic                 rise, win_end;

  assign rise    = smp[SYNC_STAGES-1] & ~smp[SYNC_STAGES];
  assign win_end = (win_cnt == WIN_LAST);
  assign tot     = (rise && ecnt != EMIN) ? ecnt + EC_ONE : ecnt;

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      smp     <= '0;
      win_cnt <= '0;
      ecnt    <= '0;
      present <= 1'b0;
    end else begin
      smp <= {smp[SYNC_STAGES-1:0], clk_div};
      if (win_end) begin
        win_cnt <= '0;
        ecnt    <= '0;
        if (tot >= EMIN)     present <= 1'b1;
        else if (tot == '0)  present <= 1'b0;
      end else begin
        win_cnt <= win_cnt + WIN_ONE;
        ecnt    <= tot;
      end
    end
  end
endmodule

// File: rtl/clksel_handover.sv
// Break-before-make gate control: each gate changes on the falling edge of its own clock.
module clksel_handover (
  input  logic clk_int,
  input  logic clk_div,
  input  logic rst_n,
  input  logic mode_en,
  input  logic ext_present,
  output logic int_on,
  output logic ext_on
);
  logic [1:0] mode_s;
  logic       mode_q, want_int;
  logic       kill_q, ext_req_q;
  logic       int_s1, ext_s1;

  assign mode_q   = mode_s[1];
  assign want_int = mode_q & ~ext_present;

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      mode_s    <= '0;
      kill_q    <= 1'b1;
      ext_req_q <= 1'b0;
      int_s1    <= 1'b0;
    end else begin
      mode_s    <= {mode_s[0], mode_en};
      kill_q    <= ~ext_present;
      ext_req_q <= mode_q & ext_present;
      int_s1    <= want_int & ~ext_on;
    end
  end

  always_ff @(negedge clk_int or negedge rst_n) begin
    if (!rst_n) int_on <= 1'b0;
    else        int_on <= int_s1;
  end

  // A stopped external clock cannot clock its own gate shut, hence the asynchronous clear.
  always_ff @(posedge clk_div or posedge kill_q) begin
    if (kill_q) ext_s1 <= 1'b0;
    else        ext_s1 <= ext_req_q & ~int_on;
  end

  always_ff @(negedge clk_div or posedge kill_q) begin
    if (kill_q) ext_on <= 1'b0;
    else        ext_on <= ext_s1;
  end
endmodule

// File: rtl/clk_source_select.sv
module clk_source_select #(
  parameter int WIN_CYC     = 16,
  parameter int EDGE_MIN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_int,
  input  logic                       clk_ext,
  input  logic                       rst_n,
  input  logic [clksel_pkg::CODE_W-1:0] div_code,
  input  logic                       mode_en,
  output logic                       clk_out,
  output logic                       src_ext,
  output logic                       ext_present
);
  logic clk_div, int_on, ext_on;

  clksel_divider u_div (
    .clk_ext (clk_ext),
    .rst_n   (rst_n),
    .div_code(div_code),
    .clk_div (clk_div)
  );

  clksel_detect #(
    .WIN_CYC    (WIN_CYC),
    .EDGE_MIN   (EDGE_MIN),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_det (
    .clk_int(clk_int),
    .rst_n  (rst_n),
    .clk_div(clk_div),
    .present(ext_present)
  );

  clksel_handover u_hand (
    .clk_int    (clk_int),
    .clk_div    (clk_div),
    .rst_n      (rst_n),
    .mode_en    (mode_en),
    .ext_present(ext_present),
    .int_on     (int_on),
    .ext_on     (ext_on)
  );

  assign clk_out = (clk_int & int_on) | (clk_div & ext_on);
  assign src_ext = ext_on;
endmodule

// File: rtl/clksel_checker.sv
module clksel_checker (
  input logic clk_int,
  input logic rst_n,
  input logic mode_en,
  input logic int_on,
  input logic ext_on,
  input logic ext_present
);
  AST_ONE_GATE: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(int_on && ext_on)); // R7

  AST_INT_WAITS: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(int_on) |-> !ext_on); // R7

  AST_EXT_DROPS: assert property (@(posedge clk_int) disable iff (!rst_n)
    (!ext_present && !$past(ext_present)) |-> !ext_on); // R5

  AST_QUIET_OFF: assert property (@(posedge clk_int) disable iff (!rst_n)
    (!mode_en && !$past(mode_en) && !$past(mode_en, 2) && !$past(mode_en, 3)) |-> !int_on); // R6
endmodule

bind clk_source_select clksel_checker u_chk (
  .clk_int    (clk_int),
  .rst_n      (rst_n),
  .mode_en    (mode_en),
  .int_on     (int_on),
  .ext_on     (ext_on),
  .ext_present(ext_present)
);

// File: tb/sim_clk_source_select.sv
`timescale 1ns/1ps
module sim_clk_source_select;
  logic       clk = 1'b0;
  logic       clk_ext = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] div_code = 3'd0;
  logic       mode_en = 1'b0;
  logic       clk_out, src_ext, ext_present;
  int         ext_hp_ps = 0;

  int checks = 0;
  int errors = 0;

  // code, external half period (ps), expected divide ratio
  localparam int VEC_N = 8;
  localparam int VEC [VEC_N][3] = '{
    '{0, 3200, 2},   '{1, 1600, 4},   '{2, 800, 8},   '{3, 400, 16},
    '{4, 200, 32},   '{5, 100, 64},   '{6, 50, 128},  '{7, 25, 256}
  };

  clk_source_select u0 (
    .clk_int    (clk),
    .clk_ext    (clk_ext),
    .rst_n      (rst_n),
    .div_code   (div_code),
    .mode_en    (mode_en),
    .clk_out    (clk_out),
    .src_ext    (src_ext),
    .ext_present(ext_present)
  );

  always #2 clk = ~clk;

  always begin
    if (ext_hp_ps == 0) begin
      clk_ext = 1'b0;
      wait (ext_hp_ps != 0);
    end else begin
      #(real'(ext_hp_ps) / 1000.0) clk_ext = ~clk_ext;
    end
  end

  real last_rise = 0.0, last_per = 0.0, last_chg = 0.0, min_w = 1.0e9;
  int  rise_cnt = 0;
  bit  mon_on = 1'b0;

  always @(posedge clk_out) begin
    last_per  = $realtime - last_rise;
    last_rise = $realtime;
    rise_cnt++;
  end

  always @(clk_out) begin
    if (mon_on && ($realtime - last_chg) < min_w) min_w = $realtime - last_chg;
    last_chg = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint per_ps();
    return longint'(last_per * 1000.0);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ext_start(input int hp);
    @(posedge clk);
    #1.003;
    ext_hp_ps = hp;
  endtask

  initial begin
    cyc(5);
    chk(clk_out == 1'b0, "R2", "clk_out in reset", clk_out, 0);
    chk(src_ext == 1'b0, "R2", "src_ext in reset", src_ext, 0);
    chk(ext_present == 1'b0, "R2", "ext_present in reset", ext_present, 0);
    rst_n = 1'b1;
    cyc(2);
    mode_en = 1'b1;
    cyc(20);
    mon_on = 1'b1;
    chk(src_ext == 1'b0, "R2", "src_ext after reset", src_ext, 0);
    chk(ext_present == 1'b0, "R2", "present without ext", ext_present, 0);
    chk(per_ps() == 4000, "R2", "internal period ps", per_ps(), 4000);

    for (int i = 0; i < VEC_N; i++) begin
      longint exp_ps;
      div_code = VEC[i][0][2:0];
      exp_ps = 2 * longint'(VEC[i][1]) * longint'(VEC[i][2]);
      ext_start(VEC[i][1]);
      cyc(8);
      chk(ext_present == 1'b0, "R3", "present too early", ext_present, 0);
      cyc(52);
      chk(ext_present == 1'b1, "R3", "present after activity", ext_present, 1);
      chk(src_ext == 1'b1, "R4", "handover to ext", src_ext, 1);
      chk(per_ps() > exp_ps - 5 && per_ps() < exp_ps + 5, "R1", "divided period ps", per_ps(), exp_ps);
      @(posedge clk); #1;
      ext_hp_ps = 0;
      cyc(60);
      chk(ext_present == 1'b0, "R5", "present after stop", ext_present, 0);
      chk(src_ext == 1'b0, "R5", "src_ext after stop", src_ext, 0);
      chk(per_ps() == 4000, "R5", "internal period after stop ps", per_ps(), 4000);
    end

    // deep sleep with the external clock running
    div_code = 3'd2;
    ext_start(800);
    cyc(60);
    chk(src_ext == 1'b1, "R4", "ext selected before sleep", src_ext, 1);
    mode_en = 1'b0;
    cyc(10);
    begin
      int r0;
      r0 = rise_cnt;
      cyc(30);
      chk(rise_cnt == r0, "R6", "clk_out rises in sleep (ext)", rise_cnt - r0, 0);
      chk(clk_out == 1'b0, "R6", "clk_out level in sleep", clk_out, 0);
      chk(src_ext == 1'b0, "R6", "src_ext in sleep", src_ext, 0);
    end
    mode_en = 1'b1;
    cyc(30);
    chk(src_ext == 1'b1, "R4", "ext after wake", src_ext, 1);
    chk(per_ps() == 12800, "R1", "period after wake ps", per_ps(), 12800);

    // deep sleep on the internal oscillator
    @(posedge clk); #1;
    ext_hp_ps = 0;
    cyc(60);
    mode_en = 1'b0;
    cyc(10);
    begin
      int r0;
      r0 = rise_cnt;
      cyc(30);
      chk(rise_cnt == r0, "R6", "clk_out rises in sleep (int)", rise_cnt - r0, 0);
    end
    mode_en = 1'b1;
    cyc(20);
    chk(per_ps() == 4000, "R2", "internal period after wake ps", per_ps(), 4000);

    chk(min_w >= 1.9, "R7", "shortest clk_out pulse ps", longint'(min_w * 1000.0), 2000);
    mon_on = 1'b0;

    // reset while the external source is active
    ext_start(800);
    cyc(60);
    chk(ext_present == 1'b1, "R3", "present before reset", ext_present, 1);
    rst_n = 1'b0;
    cyc(3);
    chk(ext_present == 1'b0, "R2", "present in mid-run reset", ext_present, 0);
    chk(src_ext == 1'b0, "R2", "src_ext in mid-run reset", src_ext, 0);
    chk(clk_out == 1'b0, "R2", "clk_out in mid-run reset", clk_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule